// File: doc/BRIEF.md
# Halted-Core Status Register Write Guard

This block holds two architectural registers of a processor core: the program status word (condition flags, interrupt masks, execution mode) and the security configuration word, whose bit 0 selects the non-secure world. While the core is halted for debugging, an external debugger may write either register. For each field of a requested write, the block decides in the same clock cycle whether the new value lands or is dropped without notice. It uses the current mode, the current security world and the two debug enable inputs (a general invasive enable and a secure-world invasive enable) to make that decision.

A write to the configuration word that is not permitted changes nothing. It raises a single-cycle undefined-instruction pulse, which the rest of the debug logic uses to take the exception. The write inputs are plain strobes that are always accepted. There is no ready signal and no back-pressure, and each strobed write is resolved at the next rising clock edge.

Top module: `dbg_psr_guard`

## Requirements
- R1: After reset, the status word is 32'h0000_01D3 (secure Supervisor mode with the A, I and F masks, bits [8:6], set), the configuration word is zero, and the undefined pulse is low.
- R2: While `halted` is low, both write strobes have no effect: neither register changes and no undefined pulse is raised.
- R3: On a status write while halted, every bit outside the mask field [8:6] and the mode field [4:0] is always written, condition flags [31:27] included.
- R4: When `dbg_en` and `spid_en` are both high, a status write may set the mode field to Monitor (5'b10110) and may change the mask bits and the mode field, whatever the current mode and world.
- R5: In secure User mode (mode 5'b10000, configuration bit 0 clear), with the enables not both high, the mode field and the mask bits of a status write are ignored.
- R6: In a secure mode other than User, a status write may change the mask bits and may set any mode, Monitor included, whatever the enables.
- R7: In the non-secure world (configuration bit 0 set) outside Monitor mode, with the enables not both high, a status write that sets Monitor mode leaves the mode field unchanged, while the mask bits and a change to any other mode are applied.
- R8: Monitor mode counts as secure privileged even when configuration bit 0 is set, for both the status-word and the configuration-word permission.
- R9: A configuration write is applied only in a secure privileged mode, or in secure User mode with both enables high. In the non-secure world outside Monitor mode it is refused, even with both enables high.
- R10: A refused configuration write while halted leaves the configuration word unchanged and drives `undef_pulse` high for exactly the cycle after the write edge.
- R11: All permission decisions in a cycle use the register values held before that edge, so a status write and a configuration write in the same cycle are both judged against the old mode and world.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| halted | input | 1 | Core is in debug state; gates all writes |
| dbg_en | input | 1 | Invasive debug enable |
| spid_en | input | 1 | Secure invasive debug enable |
| psr_wr_valid | input | 1 | Status-word write strobe |
| psr_wr_data | input | 32 | Requested status-word value |
| scr_wr_valid | input | 1 | Configuration-word write strobe |
| scr_wr_data | input | 32 | Requested configuration-word value |
| psr_q | output | 32 | Current status word |
| scr_q | output | 32 | Current configuration word |
| undef_pulse | output | 1 | Refused configuration write, one cycle after the edge |

## Verification
The assertions assume that the debug enables and the halt flag are stable across each sampling edge. They also assume that the mode field only ever holds encodings the core defines, so that any value other than User is treated as privileged. The stimulus changes every input on the falling clock edge. It draws requested modes only from User, Monitor, Supervisor, System and IRQ, so every mode the block reaches stays within that set. The directed passes walk the core through each cell of the permission matrix. A random pass then combines both strobes, both enables and the halt flag freely.

// File: rtl/dbg_psr_pkg.sv
package dbg_psr_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned MODE_W  = 5;
  localparam int unsigned MASK_LO = 6;
  localparam int unsigned MASK_HI = 8;
  localparam int unsigned NS_POS  = 0;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_MON = 5'b10110;
  localparam logic [XLEN-1:0]   PSR_RST  = 32'h0000_01D3;
  localparam logic [XLEN-1:0]   SCR_RST  = '0;

  typedef struct packed {
    logic to_mon_ok;   // mode field may become Monitor
    logic priv_ok;     // mask bits and non-Monitor mode change allowed
    logic scr_ok;      // configuration word may be written
  } perm_t;
endpackage

// File: rtl/dbg_perm_eval.sv
module dbg_perm_eval
  import dbg_psr_pkg::*;
(
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              ns_bit,
  input  logic              dbg_en,
  input  logic              spid_en,
  output perm_t             perm
);
  logic in_mon, in_usr, secure, both_en;

  always_comb begin
    in_mon  = (cur_mode == MODE_MON);
    in_usr  = (cur_mode == MODE_USR);
    // Monitor counts as secure regardless of the world bit (R8)
    secure  = !ns_bit || in_mon;
    both_en = dbg_en && spid_en;
    perm.to_mon_ok = both_en || (secure && !in_usr);
    perm.priv_ok   = both_en || !(secure && in_usr);
    perm.scr_ok    = secure && (!in_usr || both_en);
  end
endmodule

// File: rtl/dbg_psr_reg.sv
module dbg_psr_reg
  import dbg_psr_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  perm_t        perm,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MASK_FIELD = ((W'(1) << (MASK_HI + 1)) - (W'(1) << MASK_LO));
  localparam logic [W-1:0] MODE_FIELD = (W'(1) << MODE_W) - W'(1);

  logic         mode_allow;
  logic [W-1:0] upd_mask;
  logic [W-1:0] nxt;

  always_comb begin
    mode_allow = (wdata[MODE_W-1:0] == MODE_MON) ? perm.to_mon_ok : perm.priv_ok;
    upd_mask   = '1;
    if (!perm.priv_ok) upd_mask = upd_mask & ~MASK_FIELD;
    if (!mode_allow)   upd_mask = upd_mask & ~MODE_FIELD;
    nxt = (wdata & upd_mask) | (q & ~upd_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= W'(PSR_RST);
    else if (wr_en) q <= nxt;
  end

  // R3: unprivileged fields always follow the write data
  p_flags_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q[W-1:MASK_HI+1] == $past(wdata[W-1:MASK_HI+1]));

  // R5/R7: refused mask update keeps the masks
  p_masks_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !perm.priv_ok) |=> $stable(q[MASK_HI:MASK_LO]));

  // R7: refused move to Monitor keeps the mode
  p_mon_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !perm.to_mon_ok && wdata[MODE_W-1:0] == MODE_MON)
      |=> $stable(q[MODE_W-1:0]));
endmodule

// File: rtl/dbg_scr_reg.sv
module dbg_scr_reg
  import dbg_psr_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  input  logic         allow,
  output logic [W-1:0] q,
  output logic         undef_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= W'(SCR_RST);
      undef_o <= 1'b0;
    end else begin
      if (wr_req && allow) q <= wdata;
      undef_o <= wr_req && !allow;
    end
  end

  // R10: a pulse means the word did not move
  p_undef_keeps_scr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> $stable(q));

  // R9: an accepted write lands
  p_scr_applied_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && allow) |=> (q == $past(wdata)) && !undef_o);
endmodule

// File: rtl/dbg_psr_guard.sv
module dbg_psr_guard
  import dbg_psr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halted,
  input  logic            dbg_en,
  input  logic            spid_en,
  input  logic            psr_wr_valid,
  input  logic [XLEN-1:0] psr_wr_data,
  input  logic            scr_wr_valid,
  input  logic [XLEN-1:0] scr_wr_data,
  output logic [XLEN-1:0] psr_q,
  output logic [XLEN-1:0] scr_q,
  output logic            undef_pulse
);
  perm_t perm;
  logic  psr_we, scr_req;

  assign psr_we  = halted && psr_wr_valid;
  assign scr_req = halted && scr_wr_valid;

  dbg_perm_eval u_perm (
    .cur_mode (psr_q[MODE_W-1:0]),
    .ns_bit   (scr_q[NS_POS]),
    .dbg_en   (dbg_en),
    .spid_en  (spid_en),
    .perm     (perm)
  );

  dbg_psr_reg #(.W(XLEN)) u_psr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (psr_we),
    .wdata (psr_wr_data),
    .perm  (perm),
    .q     (psr_q)
  );

  dbg_scr_reg #(.W(XLEN)) u_scr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (scr_req),
    .wdata   (scr_wr_data),
    .allow   (perm.scr_ok),
    .q       (scr_q),
    .undef_o (undef_pulse)
  );

  // R2: outside debug state nothing moves
  p_idle_no_effect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> $stable(psr_q) && $stable(scr_q) && !undef_pulse);

  // R8: in Monitor, configuration writes are never refused
  p_mon_scr_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && scr_wr_valid && psr_q[MODE_W-1:0] == MODE_MON) |=> !undef_pulse);

  // R9: non-secure non-Monitor configuration writes always refused
  p_ns_scr_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && scr_wr_valid && scr_q[NS_POS] && psr_q[MODE_W-1:0] != MODE_MON)
      |=> undef_pulse);
endmodule

// File: tb/dbg_psr_guard_tb.sv
`timescale 1ns/1ps
module dbg_psr_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halted = 1'b0, dbg_en = 1'b0, spid_en = 1'b0;
  logic        psr_wr_valid = 1'b0, scr_wr_valid = 1'b0;
  logic [31:0] psr_wr_data = '0, scr_wr_data = '0;
  logic [31:0] psr_q, scr_q;
  logic        undef_pulse;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_psr, m_scr;
  logic        m_undef;

  always #2 clk = ~clk;

  dbg_psr_guard u_dut (
    .clk(clk), .rst_n(rst_n), .halted(halted), .dbg_en(dbg_en), .spid_en(spid_en),
    .psr_wr_valid(psr_wr_valid), .psr_wr_data(psr_wr_data),
    .scr_wr_valid(scr_wr_valid), .scr_wr_data(scr_wr_data),
    .psr_q(psr_q), .scr_q(scr_q), .undef_pulse(undef_pulse)
  );

  task automatic chk32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk32(tag, "psr", psr_q, m_psr);
    chk32(tag, "scr", scr_q, m_scr);
    chk32(tag, "undef", {31'b0, undef_pulse}, {31'b0, m_undef});
  endtask

  // Reference: evaluates the permission table from the requirements.
  task automatic model_step();
    logic [4:0]  mode = m_psr[4:0];
    bit          world_secure, user, mon, both;
    bit          may_mon, may_priv, may_scr;
    logic [31:0] np = m_psr, ns = m_scr;
    bit          nu = 0;
    mon   = (mode == 5'b10110);
    user  = (mode == 5'b10000);
    world_secure = (m_scr[0] == 1'b0) || mon;
    both  = dbg_en && spid_en;
    if (both) begin
      may_mon = 1; may_priv = 1;
    end else if (!world_secure) begin
      may_mon = 0; may_priv = 1;
    end else if (user) begin
      may_mon = 0; may_priv = 0;
    end else begin
      may_mon = 1; may_priv = 1;
    end
    may_scr = world_secure && (!user || both);
    if (halted && psr_wr_valid) begin
      for (int b = 0; b < 32; b++) begin
        if (b >= 6 && b <= 8)  begin if (may_priv) np[b] = psr_wr_data[b]; end
        else if (b <= 4) begin
          if ((psr_wr_data[4:0] == 5'b10110) ? may_mon : may_priv) np[b] = psr_wr_data[b];
        end
        else np[b] = psr_wr_data[b];
      end
    end
    if (halted && scr_wr_valid) begin
      if (may_scr) ns = scr_wr_data;
      else nu = 1;
    end
    m_psr = np; m_scr = ns; m_undef = nu;
  endtask

  task automatic step(string tag, bit h, bit de, bit se, bit pv, logic [31:0] pd,
                      bit sv, logic [31:0] sd);
    halted = h; dbg_en = de; spid_en = se;
    psr_wr_valid = pv; psr_wr_data = pd;
    scr_wr_valid = sv; scr_wr_data = sd;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [4:0] pick_mode(int k);
    case (k)
      0: return 5'b10000;
      1: return 5'b10110;
      2: return 5'b10011;
      3: return 5'b11111;
      default: return 5'b10010;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_psr = 32'h0000_01D3; m_scr = '0; m_undef = 0;
    compare("R1");

    // R2: ignored outside debug state
    step("R2", 0, 1, 1, 1, 32'hF000_0016, 1, 32'h1);
    // R6: secure Supervisor -> User, masks cleared, flags set
    step("R6", 1, 0, 0, 1, 32'h8000_0010, 0, 0);
    // R5: secure User tries Monitor with masks; only flags land (R3)
    step("R5", 1, 0, 0, 1, 32'h4000_01D6, 0, 0);
    // R5: secure User tries Supervisor
    step("R5", 1, 1, 0, 1, 32'h0000_0013, 0, 0);
    // R10: secure User, enables low, configuration write refused
    step("R10", 1, 0, 0, 0, 0, 1, 32'h1);
    step("R10", 1, 0, 0, 0, 0, 0, 0);
    // R4: both enables, User -> Monitor
    step("R4", 1, 1, 1, 1, 32'h2000_01D6, 0, 0);
    // R8: Monitor may enter non-secure world
    step("R8", 1, 0, 0, 0, 0, 1, 32'h1);
    // R8: Monitor with NS set still privileged for masks
    step("R8", 1, 0, 0, 1, 32'h0000_0016, 0, 0);
    // R8: configuration write in Monitor with NS set
    step("R8", 1, 0, 0, 0, 0, 1, 32'h0000_0005);
    // R6/R8: Monitor -> Supervisor in non-secure world
    step("R8", 1, 0, 0, 1, 32'h0000_0013, 0, 0);
    // R7: non-secure Supervisor, Monitor refused, masks applied
    step("R7", 1, 0, 1, 1, 32'h0000_01D6, 0, 0);
    // R7: non-secure change to System allowed
    step("R7", 1, 0, 0, 1, 32'h0000_001F, 0, 0);
    // R9: non-secure configuration write refused even with both enables
    step("R9", 1, 1, 1, 0, 0, 1, 32'h0);
    // R7: non-secure System -> User
    step("R7", 1, 0, 0, 1, 32'h0000_0010, 0, 0);
    // R7: non-secure User masks allowed, Monitor refused
    step("R7", 1, 0, 0, 1, 32'h0000_01D6, 0, 0);
    // R4: non-secure User -> Monitor with both enables
    step("R4", 1, 1, 1, 1, 32'h0000_0016, 0, 0);
    // R11: same-cycle writes judged by old Monitor state
    step("R11", 1, 0, 0, 1, 32'h0000_0010, 1, 32'h0);
    // R11: secure User, both writes refused together
    step("R11", 1, 0, 0, 1, 32'h0000_01D3, 1, 32'h1);
    // R9: secure User with both enables may write configuration
    step("R9", 1, 1, 1, 0, 0, 1, 32'h0);
    step("R2", 0, 0, 0, 0, 0, 1, 32'h1);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] pd = $urandom;
      pd[4:0] = pick_mode($urandom_range(0, 4));
      step("R11", ($urandom_range(0, 5) != 0), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), pd, ($urandom_range(0, 2) == 0), {31'($urandom), 1'($urandom)});
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule